// File: doc/BRIEF.md
# Dual-Master Paged RAM with Per-Page Conflict Arbitration

This block is a RAM shared by two independent bus masters, called port A and port B. The storage is split into pages, and each page is a separate bank with its own single access slot per cycle. When the two ports address different pages in the same cycle, both are served at once. When they address the same page, one port is accepted and the other is held for a cycle. Both accesses still complete with correct data. The winner of a same-page conflict alternates between the ports, so neither port can starve.

Every page keeps its latest write in a one-entry posted-write buffer. That write reaches the array only when the page is accessed again. A read of the buffered address is answered from the buffer. Each page also has an enable input and a write-enable input. Dropping either input while a write is still posted discards that write. Software therefore touches the page once, with a read, to flush it before turning either control off.

Each port uses a valid/ready handshake. Read data comes back exactly one cycle after the request is accepted. A port that is stalled keeps its request stable until it is accepted.

Top module: `paged_dual_ram`

## Requirements
- R1: When both ports request the same page in the same cycle, exactly one of them sees ready high. The other is accepted in a later cycle, and both accesses complete with correct data.
- R2: When both ports request different pages in the same cycle, both see ready high in that cycle.
- R3: The first same-page conflict after reset is granted to port A. Each later conflict is granted to the port that lost the previous conflict.
- R4: A port's address is a byte address. The page index is taken from address bits [15:14]. The word within the page is taken from bits [7:2]. Bits [13:8] and [1:0] do not select storage, so addresses that differ only in those bits reach the same word.
- R5: For an accepted read, rvalid is high for exactly the next cycle, and rdata holds the result in that cycle. An accepted write produces no rvalid.
- R6: A write is first held in its page's posted buffer. A read of the buffered word returns the buffered data. A read of any other word returns the array contents.
- R7: An accepted read or write to a page commits that page's posted write to the array. Once committed, the data survives a later drop of the page controls. A write that was still posted when the controls dropped is lost.
- R8: While page_en for a page is 0, requests to that page are still accepted. Reads return zero, writes are ignored, and any posted write of that page is discarded.
- R9: While page_wen for a page is 0 and page_en is 1, writes to that page are accepted but discarded, and reads return the committed array data. Any posted write of that page is discarded.
- R10: After reset, rvalid is 0 on both ports, and an idle port shows ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_en | input | NPAGES | Per-page enable (1 = page active) |
| page_wen | input | NPAGES | Per-page write enable (1 = writes stored) |
| a_valid | input | 1 | Port A request valid |
| a_ready | output | 1 | Port A request accepted this cycle |
| a_we | input | 1 | Port A request is a write |
| a_addr | input | ADDR_W | Port A byte address |
| a_wdata | input | DATA_W | Port A write data |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata | output | DATA_W | Port A read data |
| b_valid | input | 1 | Port B request valid |
| b_ready | output | 1 | Port B request accepted this cycle |
| b_we | input | 1 | Port B request is a write |
| b_addr | input | ADDR_W | Port B byte address |
| b_wdata | input | DATA_W | Port B write data |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata | output | DATA_W | Port B read data |

## Verification
The bench drives single-port traffic, simultaneous traffic to distinct pages, and simultaneous traffic to one page, and it counts the stall cycles on each port. These stall counts separate true parallel service from serialization, and they also show whether the grant order alternates. Reads that follow an aliased address, a posted write, and a committed write tell apart the forwarding path, the array path, and the address decode. Each page control is toggled at two moments, once with a write still posted and once after a flushing read, which shows when the posted data is lost and when it is kept.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  // Extract an unsigned bit field [lsb +: bits] from an address.
  function automatic int unsigned field_of(logic [31:0] addr, int lsb, int bits);
    logic [31:0] shifted;
    shifted = addr >> lsb;
    return int'(shifted & ((32'd1 << bits) - 32'd1));
  endfunction

endpackage

// File: rtl/pdr_arbiter.sv
module pdr_arbiter #(
  parameter int PAGE_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a_valid,
  input  logic                 b_valid,
  input  logic [PAGE_BITS-1:0] a_pg,
  input  logic [PAGE_BITS-1:0] b_pg,
  output logic                 a_ready,
  output logic                 b_ready,
  output logic                 conflict,
  output logic                 a_wins
);
  logic prefer_a;

  assign conflict = a_valid & b_valid & (a_pg == b_pg);
  assign a_wins   = prefer_a;
  assign a_ready  = ~conflict | prefer_a;
  assign b_ready  = ~conflict | ~prefer_a;

  // Rotate priority after every conflict so the loser goes first next time.
  always_ff @(posedge clk) begin
    if (!rst_n) prefer_a <= 1'b1;
    else if (conflict) prefer_a <= ~prefer_a;
  end
endmodule

// File: rtl/pdr_bank.sv
module pdr_bank #(
  parameter int DATA_W   = 32,
  parameter int OFF_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                wen,
  input  logic                acc,
  input  logic                acc_we,
  input  logic [OFF_BITS-1:0] acc_off,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << OFF_BITS;

  logic [DATA_W-1:0]   mem [DEPTH];
  logic                buf_vld;
  logic [OFF_BITS-1:0] buf_off;
  logic [DATA_W-1:0]   buf_data;
  logic                live;
  logic                fwd_hit;
  logic                commit;

  assign live    = en & wen;
  assign fwd_hit = acc & ~acc_we & live & buf_vld & (buf_off == acc_off);
  assign commit  = acc & live & buf_vld;

  always_ff @(posedge clk) begin
    if (commit) mem[buf_off] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_off  <= '0;
      buf_data <= '0;
    end else if (!live) begin
      buf_vld <= 1'b0;
    end else if (acc) begin
      buf_vld <= acc_we;
      if (acc_we) begin
        buf_off  <= acc_off;
        buf_data <= acc_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (acc && !acc_we) begin
      if (!en)          rdata <= '0;
      else if (fwd_hit) rdata <= buf_data;
      else              rdata <= mem[acc_off];
    end
  end
endmodule

// File: rtl/paged_dual_ram.sv
module paged_dual_ram #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 2,
  parameter int PAGE_LSB  = 14,
  parameter int OFF_BITS  = 6,
  parameter int OFF_LSB   = 2,
  localparam int NPAGES   = 1 << PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAGES-1:0] page_en,
  input  logic [NPAGES-1:0] page_wen,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_rvalid,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              b_rvalid,
  output logic [DATA_W-1:0] b_rdata
);
  logic [PAGE_BITS-1:0] a_pg, b_pg, a_rpg, b_rpg;
  logic [OFF_BITS-1:0]  a_off, b_off;
  logic                 conflict, a_wins, a_fire, b_fire;
  logic [DATA_W-1:0]    bank_rd [NPAGES];

  assign a_pg  = PAGE_BITS'(pdr_pkg::field_of(32'(a_addr), PAGE_LSB, PAGE_BITS));
  assign b_pg  = PAGE_BITS'(pdr_pkg::field_of(32'(b_addr), PAGE_LSB, PAGE_BITS));
  assign a_off = OFF_BITS'(pdr_pkg::field_of(32'(a_addr), OFF_LSB, OFF_BITS));
  assign b_off = OFF_BITS'(pdr_pkg::field_of(32'(b_addr), OFF_LSB, OFF_BITS));

  pdr_arbiter #(.PAGE_BITS(PAGE_BITS)) u_arb (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .b_valid(b_valid),
    .a_pg(a_pg), .b_pg(b_pg), .a_ready(a_ready), .b_ready(b_ready),
    .conflict(conflict), .a_wins(a_wins)
  );

  assign a_fire = a_valid & a_ready;
  assign b_fire = b_valid & b_ready;

  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    logic a_hit, b_hit;
    assign a_hit = a_fire & (a_pg == PAGE_BITS'(p));
    assign b_hit = b_fire & (b_pg == PAGE_BITS'(p));
    pdr_bank #(.DATA_W(DATA_W), .OFF_BITS(OFF_BITS)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(page_en[p]), .wen(page_wen[p]),
      .acc(a_hit | b_hit),
      .acc_we(b_hit ? b_we : a_we),
      .acc_off(b_hit ? b_off : a_off),
      .acc_wdata(b_hit ? b_wdata : a_wdata),
      .rdata(bank_rd[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
      a_rpg    <= '0;
      b_rpg    <= '0;
    end else begin
      a_rvalid <= a_fire & ~a_we;
      b_rvalid <= b_fire & ~b_we;
      a_rpg    <= a_pg;
      b_rpg    <= b_pg;
    end
  end

  assign a_rdata = bank_rd[a_rpg];
  assign b_rdata = bank_rd[b_rpg];
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker #(
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 2,
  localparam int NPAGES   = 1 << PAGE_BITS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPAGES-1:0]    page_en,
  input logic                 a_valid,
  input logic                 a_ready,
  input logic                 a_we,
  input logic                 a_rvalid,
  input logic [DATA_W-1:0]    a_rdata,
  input logic                 b_valid,
  input logic                 b_ready,
  input logic                 b_we,
  input logic                 b_rvalid,
  input logic [PAGE_BITS-1:0] a_pg,
  input logic [PAGE_BITS-1:0] b_pg,
  input logic                 conflict
);
  a_r1_one_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && a_pg == b_pg) |-> (a_ready != b_ready));

  a_r2_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && b_valid && a_pg != b_pg) |-> (a_ready && b_ready));

  a_r3_rotate_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && a_ready) |=> (!conflict || b_ready));

  a_r3_rotate_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && b_ready) |=> (!conflict || a_ready));

  a_r5_a_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && !a_we) |=> a_rvalid);

  a_r5_a_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && a_ready && !a_we) |=> !a_rvalid);

  a_r5_b_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_ready && !b_we) |=> b_rvalid);

  a_r8_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && !a_we && !page_en[a_pg]) |=> (a_rdata == '0));
endmodule

bind paged_dual_ram pdr_checker #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .page_en(page_en),
  .a_valid(a_valid), .a_ready(a_ready), .a_we(a_we), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
  .b_valid(b_valid), .b_ready(b_ready), .b_we(b_we), .b_rvalid(b_rvalid),
  .a_pg(a_pg), .b_pg(b_pg), .conflict(conflict)
);

// File: tb/paged_dual_ram_bench.sv
`timescale 1ns/1ps
module paged_dual_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  page_en = 4'hF;
  logic [3:0]  page_wen = 4'hF;
  logic        v [2];
  logic        we [2];
  logic [15:0] ad [2];
  logic [31:0] wd [2];
  logic        a_ready, b_ready, a_rvalid, b_rvalid;
  logic [31:0] a_rdata, b_rdata;

  int checks = 0;
  int fails = 0;
  int wa, wb;
  int cycles = 0;
  logic [31:0] q0 [$];
  logic [31:0] q1 [$];

  always #4 clk = ~clk;

  paged_dual_ram u_paged_dual_ram (
    .clk(clk), .rst_n(rst_n), .page_en(page_en), .page_wen(page_wen),
    .a_valid(v[0]), .a_ready(a_ready), .a_we(we[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_valid(v[1]), .b_ready(b_ready), .b_we(we[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
    .b_rvalid(b_rvalid), .b_rdata(b_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic rdy_of(input int p);
    return (p == 0) ? a_ready : b_ready;
  endfunction

  function automatic logic rv_of(input int p);
    return (p == 0) ? a_rvalid : b_rvalid;
  endfunction

  // Driver: issues one request, counts stall cycles, queues the expected read data.
  task automatic drive(input int p, input logic w, input logic [15:0] addr,
                       input logic [31:0] data, input logic [31:0] exp, output int waits);
    @(negedge clk);
    v[p] = 1'b1; we[p] = w; ad[p] = addr; wd[p] = data;
    waits = 0;
    #1;
    while (!rdy_of(p)) begin
      @(negedge clk);
      waits++;
      #1;
    end
    if (!w) begin
      if (p == 0) q0.push_back(exp); else q1.push_back(exp);
    end
    @(negedge clk);
    v[p] = 1'b0;
    chk("R5 rvalid after acceptance", 32'(rv_of(p)), 32'(!w));
  endtask

  // Monitor: pops the expected item for each response and compares.
  always @(negedge clk) begin
    if (rst_n && a_rvalid) begin
      if (q0.size() == 0) chk("R5 unexpected A response", 32'd1, 32'd0);
      else chk("R6 A read data", a_rdata, q0.pop_front());
    end
    if (rst_n && b_rvalid) begin
      if (q1.size() == 0) chk("R5 unexpected B response", 32'd1, 32'd0);
      else chk("R6 B read data", b_rdata, q1.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      v[i] = 1'b0; we[i] = 1'b0; ad[i] = '0; wd[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 a_rvalid", 32'(a_rvalid), 0);
    chk("R10 b_rvalid", 32'(b_rvalid), 0);
    chk("R10 a_ready idle", 32'(a_ready), 1);
    chk("R10 b_ready idle", 32'(b_ready), 1);

    // R6 forwarding and R4 aliasing on page 0
    drive(0, 1, 16'h000C, 32'h1000_0001, 0, wa);
    drive(0, 0, 16'h000C, 0, 32'h1000_0001, wa);
    drive(0, 0, 16'h3F0E, 0, 32'h1000_0001, wa); // R4 bits 13:8 and 1:0 ignored

    // R2 different pages in parallel
    fork
      drive(0, 1, 16'h4000, 32'h1111_0001, 0, wa);
      drive(1, 1, 16'h8000, 32'h2222_0002, 0, wb);
    join
    chk("R2 A waits on distinct pages", 32'(wa), 0);
    chk("R2 B waits on distinct pages", 32'(wb), 0);
    fork
      drive(0, 0, 16'h8000, 0, 32'h2222_0002, wa);
      drive(1, 0, 16'h4000, 0, 32'h1111_0001, wb);
    join
    chk("R2 A read waits", 32'(wa), 0);
    chk("R2 B read waits", 32'(wb), 0);

    // R1 and R3 same-page conflicts on page 3
    fork
      drive(0, 1, 16'hC004, 32'h3333_0A0A, 0, wa);
      drive(1, 1, 16'hC008, 32'h3333_0B0B, 0, wb);
    join
    chk("R3 first conflict to A", 32'(wa), 0);
    chk("R1 B stalled one cycle", 32'(wb), 1);
    fork
      drive(0, 0, 16'hC008, 0, 32'h3333_0B0B, wa);
      drive(1, 0, 16'hC004, 0, 32'h3333_0A0A, wb); // R7 A write committed by B's write
    join
    chk("R3 second conflict to B", 32'(wb), 0);
    chk("R1 A stalled one cycle", 32'(wa), 1);

    // R7 and R9 on page 0 word 5
    drive(0, 1, 16'h0014, 32'hAAAA_0001, 0, wa);
    drive(0, 0, 16'h0014, 0, 32'hAAAA_0001, wa);   // commits
    drive(0, 1, 16'h0014, 32'hBBBB_0002, 0, wa);   // left posted
    @(negedge clk); page_wen[0] = 1'b0;
    drive(0, 1, 16'h0014, 32'h0000_0099, 0, wa);   // R9 discarded
    drive(0, 0, 16'h0014, 0, 32'hAAAA_0001, wa);   // R9 read works, posted dropped
    @(negedge clk); page_wen[0] = 1'b1;
    drive(0, 0, 16'h0014, 0, 32'hAAAA_0001, wa);   // R7 unflushed write lost
    drive(0, 1, 16'h0014, 32'hCCCC_0003, 0, wa);
    drive(0, 0, 16'h0014, 0, 32'hCCCC_0003, wa);   // flush by read
    @(negedge clk); page_wen[0] = 1'b0;
    @(negedge clk); page_wen[0] = 1'b1;
    drive(0, 0, 16'h0014, 0, 32'hCCCC_0003, wa);   // R7 flushed write kept

    // R8 disabled page 1
    @(negedge clk); page_en[1] = 1'b0;
    drive(0, 0, 16'h4000, 0, 32'h0, wa);           // R8 reads zero
    drive(0, 1, 16'h4000, 32'hDEAD_BEEF, 0, wa);   // R8 ignored
    chk("R8 disabled access accepted", 32'(wa), 0);
    @(negedge clk); page_en[1] = 1'b1;
    drive(0, 0, 16'h4000, 0, 32'h1111_0001, wa);

    repeat (3) @(negedge clk);
    chk("R5 no leftover A responses", 32'(q0.size()), 0);
    chk("R5 no leftover B responses", 32'(q1.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule